// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a bus-attached watchdog. Software arms it by writing an enable bit and a 4-bit interval code, then must keep it alive by writing a fixed pattern to a control register before the interval runs out. Time is measured in half-second units taken from a single-cycle tick strobe supplied by a slow clock divider outside the block. When the count runs out, the block either drives a system-reset pulse of fixed width or sets a sticky interrupt flag, depending on a 2-bit action field.

Accidental writes are guarded two ways. Only a control write with the exact reload pattern restarts the count. The action and mode registers only accept a write whose upper halfword carries the key 0x16AA.

A small state machine sequences the timer. Its states are IDLE (disabled, count frozen), COUNT (counting ticks) and PULSE (reset output held). Its transitions are: IDLE to COUNT on enable; COUNT to IDLE on disable; COUNT to PULSE on expiry with the reset action; PULSE to COUNT when the pulse width is done and the timer is still enabled; PULSE to IDLE when the pulse width is done and the timer is disabled. Expiry with any other action stays in COUNT and sets the interrupt flag.

Top module: `kwdt_top`

## Requirements
- R1: After reset both outputs are low and the status (0x00), action (0x14) and mode (0x18) registers read as zero.
- R2: A write to 0x14 or 0x18 changes the register only when write data bits 31:16 equal 0x16AA. An unkeyed write leaves the register unchanged.
- R3: Reads return 0 in bits 31:16. Offset 0x10 always reads 0. Mode reads as code in bits 7:4 and enable in bit 0. Action reads in bits 1:0.
- R4: When enabled, expiry occurs on exactly the Nth tick after the last reload. In half-second ticks, N is 1 for code 0, 2·c for codes 1 to 6, 16/20/24/28/32 for codes 7/8/9/10/11, and 32 for codes 12 to 15.
- R5: A write to 0x10 reloads the count only when bit 0 is 1 and bits 12:1 equal 0xA57. Bits above 12 are ignored. Any other value to 0x10 does not change the count.
- R6: Mode bit 0 enables the timer. While it is disabled, ticks never cause expiry. Writing only the key to 0x18 stops the timer.
- R7: On expiry with action 1, the reset output is high for exactly PULSE_CYC clock cycles, and the count then restarts from the full interval.
- R8: On expiry with action 0, 2 or 3, status bit 0 and the interrupt output go high and stay high until a write with bit 0 set to 0x00. A write to 0x00 with bit 0 clear leaves the flag set.
- R9: The count reloads when enable goes from 0 to 1, and when a keyed mode write changes the code while enabled. A mode write that keeps the same code does not reload.
- R10: The reset output rises only on expiry while enabled with action 1. Action 1 never sets the interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle half-second strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_re |
| sys_rst_o | output | 1 | System reset pulse |
| irq_o | output | 1 | Sticky expiry interrupt |

## Verification
The assertions assume that bus_we is a single-cycle strobe and that tick is a one-cycle pulse that never lands in the cycle in which a reload is applied. A tick in that cycle would be dropped in favour of the reload. The bench drives every write and every tick as separate one-cycle pulses on falling edges, so a reload is always applied before the next tick arrives. It never raises bus_we and bus_re together. Under these conditions, the pulse-width counter and the keyed-write stability checks observe only the sequences the requirements describe.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    localparam int          DATA_W     = 32;
    localparam logic [15:0] WR_KEY     = 16'h16AA;
    localparam logic [11:0] KICK_PAT   = 12'hA57;
    localparam logic [7:0]  OFF_STATUS = 8'h00;
    localparam logic [7:0]  OFF_CTRL   = 8'h10;
    localparam logic [7:0]  OFF_CFG    = 8'h14;
    localparam logic [7:0]  OFF_MODE   = 8'h18;
    localparam logic [1:0]  ACT_SYSRST = 2'd1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_PULSE = 2'd2
    } wdt_state_e;

    // interval length in half-second ticks for a 4-bit code
    function automatic int ticks_for_code(input logic [3:0] code);
        int c;
        c = int'(code);
        if (c == 0)       return 1;
        else if (c <= 6)  return 2 * c;
        else if (c <= 11) return 4 * c - 12;
        else              return 32;
    endfunction
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs #(
    parameter int ADDR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [kwdt_pkg::DATA_W-1:0] wdata,
    input  logic                       we,
    input  logic                       re,
    output logic [kwdt_pkg::DATA_W-1:0] rdata,
    input  logic                       irq_set,
    output logic                       en_q,
    output logic [3:0]                 code_q,
    output logic [1:0]                 act_q,
    output logic                       pend_q,
    output logic                       reload_q
);
    import kwdt_pkg::*;

    logic keyed, kick, mode_wr, cfg_wr, stat_clr, mode_reload;
    logic unused_wbits;

    assign unused_wbits = ^wdata[15:13];

    assign keyed    = (wdata[31:16] == WR_KEY);
    assign kick     = we && (addr == ADDR_W'(OFF_CTRL)) && wdata[0]
                      && (wdata[12:1] == KICK_PAT);
    assign mode_wr  = we && (addr == ADDR_W'(OFF_MODE)) && keyed;
    assign cfg_wr   = we && (addr == ADDR_W'(OFF_CFG)) && keyed;
    assign stat_clr = we && (addr == ADDR_W'(OFF_STATUS)) && wdata[0];
    assign mode_reload = mode_wr && wdata[0] && (!en_q || (wdata[7:4] != code_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            code_q   <= 4'd0;
            act_q    <= 2'd0;
            pend_q   <= 1'b0;
            reload_q <= 1'b0;
        end else begin
            reload_q <= kick || mode_reload;
            if (mode_wr) begin
                en_q   <= wdata[0];
                code_q <= wdata[7:4];
            end
            if (cfg_wr)
                act_q <= wdata[1:0];
            if (irq_set)
                pend_q <= 1'b1;
            else if (stat_clr)
                pend_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (re) begin
            if (addr == ADDR_W'(OFF_STATUS))
                rdata[0] = pend_q;
            else if (addr == ADDR_W'(OFF_CFG))
                rdata[1:0] = act_q;
            else if (addr == ADDR_W'(OFF_MODE)) begin
                rdata[7:4] = code_q;
                rdata[0]   = en_q;
            end
        end
    end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       run,
    input  logic       tick,
    input  logic [3:0] code,
    output logic       expire
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ivl;

    assign ivl    = CNT_W'(kwdt_pkg::ticks_for_code(code));
    assign expire = run && tick && !load && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load || expire)
            cnt_q <= ivl;
        else if (run && tick && (cnt_q != '0))
            cnt_q <= cnt_q - CNT_W'(1);
    end
endmodule

// File: rtl/kwdt_fsm.sv
module kwdt_fsm #(
    parameter int PULSE_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] act,
    input  logic       expire,
    output logic       run,
    output logic       sys_rst,
    output logic       irq_set
);
    import kwdt_pkg::*;

    localparam int PW = $clog2(PULSE_CYC + 1);

    wdt_state_e     state_q, state_d;
    logic [PW-1:0]  pcnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (en) state_d = ST_COUNT;
            ST_COUNT: begin
                if (!en)
                    state_d = ST_IDLE;
                else if (expire && (act == ACT_SYSRST))
                    state_d = ST_PULSE;
            end
            ST_PULSE: if (pcnt_q == '0) state_d = en ? ST_COUNT : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q != ST_PULSE) && (state_d == ST_PULSE))
                pcnt_q <= PW'(PULSE_CYC - 1);
            else if ((state_q == ST_PULSE) && (pcnt_q != '0))
                pcnt_q <= pcnt_q - PW'(1);
        end
    end

    always_comb begin
        run     = (state_q == ST_COUNT);
        sys_rst = (state_q == ST_PULSE);
        irq_set = (state_q == ST_COUNT) && expire && (act != ACT_SYSRST);
    end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
    parameter int ADDR_W    = 8,
    parameter int CNT_W     = 6,
    parameter int PULSE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    output logic              sys_rst_o,
    output logic              irq_o
);
    logic       en_q, pend_q, reload_q, expire, run, irq_set;
    logic [3:0] code_q;
    logic [1:0] act_q;

    kwdt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
        .we(bus_we), .re(bus_re), .rdata(bus_rdata), .irq_set(irq_set),
        .en_q(en_q), .code_q(code_q), .act_q(act_q), .pend_q(pend_q),
        .reload_q(reload_q)
    );

    kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(reload_q), .run(run), .tick(tick),
        .code(code_q), .expire(expire)
    );

    kwdt_fsm #(.PULSE_CYC(PULSE_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en_q), .act(act_q), .expire(expire),
        .run(run), .sys_rst(sys_rst_o), .irq_set(irq_set)
    );

    assign irq_o = pend_q;
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
    parameter int ADDR_W    = 8,
    parameter int PULSE_CYC = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_we,
    input logic              bus_re,
    input logic [31:0]       bus_rdata,
    input logic              sys_rst_o,
    input logic              irq_o,
    input logic              en_q,
    input logic [3:0]        code_q,
    input logic [1:0]        act_q
);
    localparam int HW = $clog2(PULSE_CYC + 2);
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_cnt <= '0;
        else if (sys_rst_o)
            hi_cnt <= hi_cnt + HW'(1);
        else
            hi_cnt <= '0;
    end

    AST_MODE_UNKEYED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr == ADDR_W'(8'h18) && bus_wdata[31:16] != 16'h16AA
        |=> $stable(en_q) && $stable(code_q)); // R2
    AST_CFG_UNKEYED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr == ADDR_W'(8'h14) && bus_wdata[31:16] != 16'h16AA
        |=> $stable(act_q)); // R2
    AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re && bus_addr == ADDR_W'(8'h10) |-> bus_rdata == 32'd0); // R3
    AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt <= HW'(PULSE_CYC)); // R7
    AST_PULSE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_o) |-> hi_cnt == HW'(PULSE_CYC)); // R7
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !(bus_we && bus_addr == ADDR_W'(8'h00) && bus_wdata[0])
        |=> irq_o); // R8
    AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> $past(en_q) && $past(act_q) == 2'd1); // R10
endmodule

bind kwdt_top kwdt_chk #(.ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .sys_rst_o(sys_rst_o), .irq_o(irq_o), .en_q(en_q), .code_q(code_q),
    .act_q(act_q)
);

// File: tb/tb_kwdt_top.sv
module tb_kwdt_top;
    localparam int PULSE = 8;
    localparam logic [31:0] KEY = 32'h16AA_0000;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0, re = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic sys_rst, irq;
    int checks = 0, errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    kwdt_top #(.ADDR_W(8), .CNT_W(6), .PULSE_CYC(PULSE)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(addr),
        .bus_wdata(wdata), .bus_we(we), .bus_re(re), .bus_rdata(rdata),
        .sys_rst_o(sys_rst), .irq_o(irq)
    );

    function automatic int n_ticks(input int c);
        if (c == 0) return 1;
        if (c <= 6) return c + c;
        if (c <= 11) return 16 + 4 * (c - 7);
        return 32;
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); re = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); re = 1'b0;
    endtask

    task automatic tk();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic pulse_len(output int n);
        n = 1;
        for (int g = 0; g < 100; g++) begin
            @(negedge clk);
            if (!sys_rst) break;
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog timeout");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(sys_rst, 0, "R1 rst");
        check(irq, 0, "R1 irq");
        rd(8'h00, r); check(r, 0, "R1 status");
        rd(8'h14, r); check(r, 0, "R1 cfg");
        rd(8'h18, r); check(r, 0, "R1 mode");

        // R2 keyed writes
        wr(8'h14, 32'h0000_0003); rd(8'h14, r); check(r, 0, "R2 cfg unkeyed");
        wr(8'h14, KEY | 32'h3); rd(8'h14, r); check(r, 3, "R2 cfg keyed");
        wr(8'h18, 32'h0000_0031); rd(8'h18, r); check(r, 0, "R2 mode unkeyed");
        rd(8'h10, r); check(r, 0, "R3 ctrl reads zero");

        // R4 sweep over every code with reset action, R7 pulse width
        wr(8'h14, KEY | 32'h1);
        for (int c = 0; c < 16; c++) begin
            wr(8'h18, KEY | (c << 4) | 1);
            rd(8'h18, r); check(r, (c << 4) | 1, "R3 mode readback");
            for (int i = 1; i <= n_ticks(c); i++) begin
                tk();
                check(sys_rst, (i == n_ticks(c)) ? 1 : 0, "R4 expiry tick");
            end
            pulse_len(n); check(n, PULSE, "R7 pulse width");
            check(irq, 0, "R10 no irq on reset action");
            wr(8'h18, KEY);
        end

        // R7 restart from full interval after pulse
        wr(8'h18, KEY | (2 << 4) | 1);
        for (int i = 1; i <= 4; i++) tk();
        pulse_len(n);
        for (int i = 1; i <= 4; i++) begin
            tk(); check(sys_rst, (i == 4) ? 1 : 0, "R7 restart interval");
        end
        pulse_len(n);
        wr(8'h18, KEY);

        // R5 reload pattern
        wr(8'h18, KEY | (1 << 4) | 1);
        tk(); check(sys_rst, 0, "R5 first tick");
        wr(8'h10, 32'h0000_14AE);
        wr(8'h10, 32'h0000_14AD);
        tk(); check(sys_rst, 1, "R5 bad kicks ignored");
        pulse_len(n);
        tk();
        wr(8'h10, 32'hFFFF_14AF);
        tk(); check(sys_rst, 0, "R5 good kick reloads");
        tk(); check(sys_rst, 1, "R5 expiry after kick");
        pulse_len(n);
        wr(8'h18, KEY);

        // R6 disable
        wr(8'h18, KEY | 32'h1);
        wr(8'h18, KEY);
        for (int i = 0; i < 3; i++) begin
            tk(); check(sys_rst, 0, "R6 stopped");
        end
        wr(8'h18, 32'h0000_0001);
        rd(8'h18, r); check(r, 0, "R6 unkeyed enable ignored");
        tk(); check(sys_rst, 0, "R6 still stopped");

        // R9 code change reloads, same code does not
        wr(8'h18, KEY | (2 << 4) | 1);
        for (int i = 0; i < 3; i++) tk();
        wr(8'h18, KEY | (1 << 4) | 1);
        tk(); check(sys_rst, 0, "R9 code change reload");
        tk(); check(sys_rst, 1, "R9 new interval");
        pulse_len(n);
        tk();
        wr(8'h18, KEY | (1 << 4) | 1);
        tk(); check(sys_rst, 1, "R9 same code no reload");
        pulse_len(n);
        wr(8'h18, KEY);

        // R8 / R10 action sweep
        for (int a = 0; a < 4; a++) begin
            wr(8'h14, KEY | a);
            wr(8'h18, KEY | 32'h1);
            tk();
            check(sys_rst, (a == 1) ? 1 : 0, "R10 reset only action 1");
            check(irq, (a != 1) ? 1 : 0, "R8 irq on other actions");
            if (a == 1) pulse_len(n);
            else begin
                rd(8'h00, r); check(r, 1, "R8 status set");
                tk(); check(irq, 1, "R8 sticky");
                wr(8'h00, 32'h0); check(irq, 1, "R8 write 0 keeps");
                wr(8'h18, KEY);
                wr(8'h00, 32'h1); check(irq, 0, "R8 w1c clears");
                rd(8'h00, r); check(r, 0, "R8 status clear");
            end
            wr(8'h18, KEY);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule